// File: doc/BRIEF.md
# Debounced Computation-Mode Sequencer

This block sits behind a switch debounce timer and picks one of four converter computation modes: plain, running mean, burst mean and low-pass. The timer hands it a single-cycle pulse each time the switch level has settled after an edge, and the block samples the settled switch level alongside that pulse. A low level with a pulse marks a validated press. A high level with a pulse marks a validated release. The mode moves on only after a press has been seen and the release that follows it is then confirmed.

The current mode is presented three ways. The first is a 2-bit code. The second is a pair of indicator lines carrying the same code. The third is a rate select that tells the trigger divider whether to use the slow interval (10 ms, 100 Hz) or the fast interval (1 ms, 1 kHz). Only the low-pass mode uses the fast interval. The block produces no timing itself; the divider downstream reads the select.

Top module: `calc_mode_sequencer`

## Requirements
- R1: While reset is held low at a clock edge, the block returns to the plain mode (code 0), the indicators read 0/0, the rate select reads 0 and any pending press is forgotten.
- R2: Each completed press-and-release advances the mode code in the order 0 (plain), 1 (running mean), 2 (burst mean), 3 (low-pass).
- R3: A completed press-and-release in the low-pass mode (code 3) returns the mode to plain (code 0).
- R4: The mode changes only on a clock edge where valid_evt is 1, sw_level is 1 and a press has been recorded since the last change. The new code appears on the outputs after that edge.
- R5: A release pulse (valid_evt 1, sw_level 1) with no recorded press leaves the mode unchanged.
- R6: Changes of sw_level while valid_evt is 0 have no effect on the mode.
- R7: Several press pulses (valid_evt 1, sw_level 0) before one release produce exactly one advance.
- R8: ind_hi equals bit 1 of the mode code and ind_lo equals bit 0.
- R9: rate_fast is 1 (1 ms interval) in the low-pass mode and 0 (10 ms interval) in the other three.
- R10: After an advance, the recorded press is cleared, so a further release pulse without a new press does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_evt | input | 1 | One-cycle pulse from the debounce timer after a settled switch edge |
| sw_level | input | 1 | Sampled switch level: 0 pressed, 1 released |
| mode_code | output | 2 | Current computation mode: 0 plain, 1 running mean, 2 burst mean, 3 low-pass |
| ind_hi | output | 1 | Indicator line, high bit of the mode code |
| ind_lo | output | 1 | Indicator line, low bit of the mode code |
| rate_fast | output | 1 | Trigger interval select: 1 means 1 ms, 0 means 10 ms |

## Verification
The bench builds the block with its default fast-mode mask, which sets only the low-pass mode bit. That default lets the rate select and the indicators be checked against one mode code every cycle. With four modes in the ring, the wrap from low-pass to plain is reached after four completed cycles. A long random run, with pulses at random levels, visits that wrap many times. It also covers stray releases, repeated presses and a reset taken while a press is pending.

// File: rtl/modesel_pkg.sv
// Shared definitions for the computation-mode sequencer.
// Assumes a fixed ring of four modes encoded in two bits.
package modesel_pkg;
    localparam int MODE_W    = 2;
    localparam int NUM_MODES = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_PLAIN = 2'd0,
        MODE_MEAN  = 2'd1,
        MODE_BURST = 2'd2,
        MODE_LPF   = 2'd3
    } calc_mode_e;
endpackage

// File: rtl/press_tracker.sv
// Records a validated press and raises a one-cycle step request when the
// validated release that follows it arrives.
// Assumes: evt_pulse is one cycle wide; pin_high is the settled level
// sampled with it (0 = pressed, 1 = released).
module press_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_pulse,
    input  logic pin_high,
    output logic step_req
);
    logic armed_q;

    // A release completes a cycle only if a press came before it.
    assign step_req = evt_pulse && pin_high && armed_q;

    // Arm on a validated press; disarm when the cycle completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (step_req) begin
            armed_q <= 1'b0;
        end else if (evt_pulse && !pin_high) begin
            armed_q <= 1'b1;
        end
    end

    AST_ARM_ON_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse && !pin_high) |=> armed_q); // R7
    AST_DISARM_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step_req |=> !armed_q); // R10
    AST_STRAY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse && pin_high && !armed_q) |=> !armed_q); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_pulse |=> $stable(armed_q)); // R6
endmodule

// File: rtl/mode_stepper.sv
// Holds the current computation mode and advances it around the ring
// on each step request, wrapping from the last mode to the first.
// Assumes step_req lasts a single cycle per completed switch cycle.
module mode_stepper
    import modesel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_req,
    output calc_mode_e mode_q
);
    localparam calc_mode_e FIRST_MODE = MODE_PLAIN;
    localparam calc_mode_e LAST_MODE  = calc_mode_e'(NUM_MODES - 1);

    calc_mode_e mode_next;

    // Next mode in the ring.
    always_comb begin
        if (mode_q == LAST_MODE) begin
            mode_next = FIRST_MODE;
        end else begin
            mode_next = calc_mode_e'(mode_q + MODE_W'(1));
        end
    end

    // Mode register, plain after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= FIRST_MODE;
        end else if (step_req) begin
            mode_q <= mode_next;
        end
    end

    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !step_req |=> $stable(mode_q)); // R4
    AST_STEP_CHANGES: assert property (@(posedge clk) disable iff (!rst_n)
        step_req |=> (mode_q != $past(mode_q))); // R2
    AST_WRAP_TO_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (step_req && mode_q == MODE_LPF) |=> (mode_q == MODE_PLAIN)); // R3
endmodule

// File: rtl/mode_indicator.sv
// Decodes the mode code into the indicator pair and the trigger-rate select.
// Assumes: the indicator pair carries the code directly; FAST_MASK holds one
// bit per mode, set where the 1 ms interval applies.
module mode_indicator
    import modesel_pkg::*;
#(
    parameter logic [NUM_MODES-1:0] FAST_MASK = 4'b1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  calc_mode_e mode,
    output logic       led_hi,
    output logic       led_lo,
    output logic       rate_fast
);
    logic [NUM_MODES-1:0] hit;

    // One-hot match of the current mode against each ring position.
    generate
        for (genvar i = 0; i < NUM_MODES; i++) begin : g_hit
            assign hit[i] = (mode == calc_mode_e'(i));
        end
    endgenerate

    // Indicator pair shows the code; rate comes from the per-mode mask.
    always_comb begin
        led_hi    = mode[1];
        led_lo    = mode[0];
        rate_fast = |(hit & FAST_MASK);
    end

    always_comb begin
        AST_SINGLE_HIT: assert ($countones(hit) == 1); // R8
    end

    AST_RATE_FOLLOWS_LEDS: assert property (@(posedge clk) disable iff (!rst_n)
        $stable({led_hi, led_lo}) |-> $stable(rate_fast)); // R9
endmodule

// File: rtl/calc_mode_sequencer.sv
// Top level: turns validated switch events into a computation-mode ring,
// an indicator pair and a trigger-rate select.
// Assumes the inputs come from a debounce timer in this clock domain.
module calc_mode_sequencer
    import modesel_pkg::*;
#(
    parameter logic [NUM_MODES-1:0] FAST_MASK = 4'b1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       valid_evt,
    input  logic       sw_level,
    output logic [1:0] mode_code,
    output logic       ind_hi,
    output logic       ind_lo,
    output logic       rate_fast
);
    logic       step_req;
    calc_mode_e mode_q;

    press_tracker u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (valid_evt),
        .pin_high  (sw_level),
        .step_req  (step_req)
    );

    mode_stepper u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_req (step_req),
        .mode_q   (mode_q)
    );

    mode_indicator #(.FAST_MASK(FAST_MASK)) u_ind (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .led_hi    (ind_hi),
        .led_lo    (ind_lo),
        .rate_fast (rate_fast)
    );

    // Expose the code as a plain vector.
    assign mode_code = mode_q;

    AST_IND_MATCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ({ind_hi, ind_lo} == mode_code)); // R8
endmodule

// File: tb/sim_calc_mode_sequencer.sv
// Bench: a behavioural reference model is compared on every clock, and
// directed scenarios check the named requirements.
module sim_calc_mode_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_evt = 1'b0;
    logic       sw_level = 1'b1;
    logic [1:0] mode_code;
    logic       ind_hi, ind_lo, rate_fast;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;
    int  ref_mode = 0;
    bit  ref_armed = 1'b0;

    calc_mode_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .valid_evt(valid_evt), .sw_level(sw_level),
        .mode_code(mode_code), .ind_hi(ind_hi), .ind_lo(ind_lo), .rate_fast(rate_fast)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: arm on a pressed pulse, advance on a released pulse when armed.
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_mode  = 0;
            ref_armed = 1'b0;
        end else if (valid_evt) begin
            if (!sw_level) begin
                ref_armed = 1'b1;
            end else if (ref_armed) begin
                ref_mode  = (ref_mode + 1) % 4;
                ref_armed = 1'b0;
            end
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(mode_code) == ref_mode, "R4 mode", int'(mode_code), ref_mode);
            chk(int'({ind_hi, ind_lo}) == ref_mode, "R8 leds", int'({ind_hi, ind_lo}), ref_mode);
            chk(int'(rate_fast) == int'(ref_mode == 3), "R9 rate", int'(rate_fast), int'(ref_mode == 3));
        end
    end

    task automatic evt(input logic lvl);
        @(negedge clk);
        sw_level  = lvl;
        valid_evt = 1'b1;
        @(negedge clk);
        valid_evt = 1'b0;
    endtask

    task automatic full_cycle();
        evt(1'b0);
        evt(1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mode_code == 2'd0, "R1 reset mode", int'(mode_code), 0);
        chk({ind_hi, ind_lo} == 2'b00, "R1 reset leds", int'({ind_hi, ind_lo}), 0);
        chk(rate_fast == 1'b0, "R1 reset rate", int'(rate_fast), 0);

        // R6: level toggles without pulses
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            sw_level = ~sw_level;
        end
        sw_level = 1'b1;
        @(negedge clk);
        chk(mode_code == 2'd0, "R6 level only", int'(mode_code), 0);

        // R5: stray release
        evt(1'b1);
        chk(mode_code == 2'd0, "R5 stray release", int'(mode_code), 0);

        // R4: press alone does not change mode, release does
        evt(1'b0);
        chk(mode_code == 2'd0, "R4 press only", int'(mode_code), 0);
        evt(1'b1);
        chk(mode_code == 2'd1, "R2 to mean", int'(mode_code), 1);

        // R7: repeated presses then one release
        evt(1'b0);
        evt(1'b0);
        evt(1'b0);
        evt(1'b1);
        chk(mode_code == 2'd2, "R7 single advance", int'(mode_code), 2);

        // R10: second release without a press
        evt(1'b1);
        chk(mode_code == 2'd2, "R10 disarmed", int'(mode_code), 2);

        full_cycle();
        chk(mode_code == 2'd3, "R2 to lowpass", int'(mode_code), 3);
        chk(rate_fast == 1'b1, "R9 fast in lowpass", int'(rate_fast), 1);
        chk({ind_hi, ind_lo} == 2'b11, "R8 leds lowpass", int'({ind_hi, ind_lo}), 3);

        full_cycle();
        chk(mode_code == 2'd0, "R3 wrap", int'(mode_code), 0);
        chk(rate_fast == 1'b0, "R9 slow in plain", int'(rate_fast), 0);

        // R1: reset clears a pending press
        full_cycle();
        evt(1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(mode_code == 2'd0, "R1 reset mid-run", int'(mode_code), 0);
        evt(1'b1);
        chk(mode_code == 2'd0, "R1 press forgotten", int'(mode_code), 0);

        // Random run against the model.
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            sw_level  = 1'($urandom_range(0, 1));
            valid_evt = ($urandom_range(0, 3) == 0);
        end
        @(negedge clk);
        valid_evt = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule